// File: doc/BRIEF.md
# Companion-chip address decoder with relocatable NAND window

This block sits between a host bus and three register targets of a companion chip. The host address space is 16 bits wide and addressed in bytes. The upper address byte selects a page. Page 0 is forwarded to the system-control register target. Page 1 holds the block's own NAND window configuration registers. A 256-byte window, whose location software sets, is forwarded to the NAND controller register target. Each target sees one byte-wide request per cycle, and its read data is returned in the same cycle.

The host may issue byte, halfword or word accesses. A wide access is split into byte accesses at ascending addresses, one per cycle. Each byte is decoded on its own, so a wide access may cross pages or wrap past the top of the address space. Read bytes are assembled little-endian. The host handshake stays busy until the last byte has been handled, and a one-cycle completion pulse then reports the result.

Top module: `ccd_router`

## Requirements
- R1: A byte whose address has upper byte 0x00 is sent to the system target: `sys_req` is high for that cycle, `sys_off` carries the low address byte, `sys_wdata` carries the write byte, and a read returns `sys_rdata`.
- R2: Page 1, offset 0x04 is the command register. A write sets the window enable from data bit 1. A read returns 0x02 when the window is enabled and 0x00 when it is disabled.
- R3: Page 1, offsets 0x10 to 0x13 hold the 32-bit window base, one byte each, with offset 0x10 holding bits 7:0. Each byte is written on its own, and a read returns the matching byte of the stored base.
- R4: Any byte address outside pages 0 and 1 is sent to the NAND target only when the window is enabled and the zero-extended 32-bit value {address[15:8], 8'h00} equals the base. The offset is the low address byte. A base with a nonzero low byte or nonzero bits 31:16 therefore never matches. Pages 0 and 1 take priority over the window.
- R5: `host_size` encodes 0 as byte, 1 as halfword (addresses a and a+1), 2 as word (a to a+3) and 3 as byte. The bytes are issued at a+k, with the address wrapping modulo 2^16, in ascending order, one per cycle. Write lane k (bits 8k+7:8k) goes to byte k, and read byte k returns in lane k.
- R6: A read of an unmatched byte returns 0, and a write to an unmatched byte is dropped. Unmatched bytes include configuration offsets other than the command register and the base bytes. An unmatched byte drives no target request.
- R7: `host_ready` is high exactly when no access is in progress. An access of n bytes accepted at one clock edge raises `host_done` for one cycle, n+1 cycles after acceptance. `host_rdata` is valid while `host_done` is high, and it is zero for writes and in lanes above the access size.
- R8: After reset the window is disabled, the base is zero, `host_ready` is high and no target request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size code (see R5) |
| host_addr | input | 16 | Byte address of the lowest byte |
| host_wdata | input | 32 | Write data, little-endian lanes |
| host_ready | output | 1 | Idle, request accepted when valid |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Assembled read data |
| sys_req | output | 1 | System target byte request |
| sys_we | output | 1 | System target write strobe |
| sys_off | output | 8 | System target register offset |
| sys_wdata | output | 8 | System target write byte |
| sys_rdata | input | 8 | System target read byte (same cycle) |
| nfc_req | output | 1 | NAND target byte request |
| nfc_we | output | 1 | NAND target write strobe |
| nfc_off | output | 8 | NAND target register offset |
| nfc_wdata | output | 8 | NAND target write byte |
| nfc_rdata | input | 8 | NAND target read byte (same cycle) |

## Verification
The hardest cases to reach are the ones where the window almost matches. Examples are a base whose page byte is right but whose low byte or upper half is nonzero, a base that points into page 1 where the configuration page must still win, and an enabled window that was disabled just before a write to it. Random traffic almost never builds such base values, so a directed sequence builds them one base byte at a time. A later read through the host port then shows whether the byte reached the NAND target. Wide accesses that straddle the page 0/1 boundary or wrap from 0xFFFF to 0x0000 are also placed directly. This shows that every byte of such an access is decoded on its own.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SYS  = 2'd1,
        TGT_CFG  = 2'd2,
        TGT_NFC  = 2'd3
    } tgt_e;

endpackage

// File: rtl/ccd_decode.sv
module ccd_decode
    import ccd_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    parameter int BASE_W = 32,
    parameter int SYS_PAGE = 0,
    parameter int CFG_PAGE = 1
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              win_en,
    input  logic [BASE_W-1:0] win_base,
    output tgt_e              tgt
);

    localparam int SPAN_W = PAGE_W + OFF_W;

    logic [BASE_W-1:0] page_base;
    logic              win_match;

    always_comb begin
        page_base = BASE_W'({page, {OFF_W{1'b0}}});
        win_match = win_en && (page_base == win_base);
        if (page == PAGE_W'(SYS_PAGE)) begin
            tgt = TGT_SYS;
        end else if (page == PAGE_W'(CFG_PAGE)) begin
            tgt = TGT_CFG;
        end else if (win_match) begin
            tgt = TGT_NFC;
        end else begin
            tgt = TGT_NONE;
        end
    end

    initial begin
        if (BASE_W < SPAN_W) $error("base narrower than address");
    end

endmodule

// File: rtl/ccd_cfg_regs.sv
module ccd_cfg_regs #(
    parameter int OFF_W    = 8,
    parameter int BASE_W   = 32,
    parameter int CMD_OFF  = 'h04,
    parameter int BASE_OFF = 'h10,
    parameter int EN_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              win_en,
    output logic [BASE_W-1:0] win_base
);

    localparam int NBYTES = BASE_W / 8;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NBYTES-1:0] lane_hit;
    logic              cmd_hit;

    assign cmd_hit = (off == OFF_W'(CMD_OFF));

    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_lane
            assign lane_hit[g] = (off == OFF_W'(BASE_OFF + g));
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        rdata = 8'h00;
        if (cmd_hit) begin
            rdata[EN_BIT] = cfg_q.en;
            if (acc && we) begin
                cfg_d.en = wdata[EN_BIT];
            end
        end
        for (int k = 0; k < NBYTES; k++) begin
            if (lane_hit[k]) begin
                rdata = cfg_q.base[8*k +: 8];
                if (acc && we) begin
                    cfg_d.base[8*k +: 8] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign win_en   = cfg_q.en;
    assign win_base = cfg_q.base;

endmodule

// File: rtl/ccd_seq.sv
module ccd_seq
    import ccd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HOST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HOST_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [HOST_W-1:0] rsp_rdata,
    output logic              b_active,
    output logic              b_we,
    output logic [ADDR_W-1:0] b_addr,
    output logic [7:0]        b_wdata,
    input  logic [7:0]        b_rdata
);

    localparam int LANES = HOST_W / 8;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [HOST_W-1:0] wdata;
        logic [HOST_W-1:0] rdata;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
    } seq_t;

    seq_t seq_d, seq_q;
    int   nbytes;

    always_comb begin
        case (req_size)
            SZ_HALF: nbytes = 2;
            SZ_WORD: nbytes = 4;
            default: nbytes = 1;
        endcase
        if (nbytes > LANES) nbytes = LANES;
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!seq_q.busy) begin
            if (req_valid) begin
                seq_d.busy  = 1'b1;
                seq_d.we    = req_write;
                seq_d.addr  = req_addr;
                seq_d.wdata = req_wdata;
                seq_d.rdata = '0;
                seq_d.idx   = '0;
                seq_d.last  = IDX_W'(nbytes - 1);
            end
        end else begin
            if (!seq_q.we) begin
                seq_d.rdata[int'(seq_q.idx)*8 +: 8] = b_rdata;
            end
            if (seq_q.idx == seq_q.last) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = !seq_q.busy;
    assign rsp_done  = seq_q.done;
    assign rsp_rdata = seq_q.rdata;
    assign b_active  = seq_q.busy;
    assign b_we      = seq_q.we;
    assign b_addr    = seq_q.addr + ADDR_W'(seq_q.idx);
    assign b_wdata   = seq_q.wdata[int'(seq_q.idx)*8 +: 8];

endmodule

// File: rtl/ccd_router.sv
module ccd_router
    import ccd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int HOST_W   = 32,
    parameter int OFF_W    = 8,
    parameter int BASE_W   = 32,
    parameter int CMD_OFF  = 'h04,
    parameter int BASE_OFF = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [1:0]        host_size,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_done,
    output logic [HOST_W-1:0] host_rdata,
    output logic              sys_req,
    output logic              sys_we,
    output logic [OFF_W-1:0]  sys_off,
    output logic [7:0]        sys_wdata,
    input  logic [7:0]        sys_rdata,
    output logic              nfc_req,
    output logic              nfc_we,
    output logic [OFF_W-1:0]  nfc_off,
    output logic [7:0]        nfc_wdata,
    input  logic [7:0]        nfc_rdata
);

    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              b_active;
    logic              b_we;
    logic [ADDR_W-1:0] byte_addr;
    logic [7:0]        b_wdata;
    logic [7:0]        b_rdata;
    logic [7:0]        cfg_rdata;
    logic              cfg_acc;
    logic              win_en;
    logic [BASE_W-1:0] win_base;
    tgt_e              tgt;

    ccd_seq #(
        .ADDR_W (ADDR_W),
        .HOST_W (HOST_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (host_valid),
        .req_write (host_write),
        .req_size  (host_size),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .req_ready (host_ready),
        .rsp_done  (host_done),
        .rsp_rdata (host_rdata),
        .b_active  (b_active),
        .b_we      (b_we),
        .b_addr    (byte_addr),
        .b_wdata   (b_wdata),
        .b_rdata   (b_rdata)
    );

    ccd_decode #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .BASE_W (BASE_W)
    ) u_decode (
        .page     (byte_addr[ADDR_W-1:OFF_W]),
        .win_en   (win_en),
        .win_base (win_base),
        .tgt      (tgt)
    );

    ccd_cfg_regs #(
        .OFF_W    (OFF_W),
        .BASE_W   (BASE_W),
        .CMD_OFF  (CMD_OFF),
        .BASE_OFF (BASE_OFF)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (cfg_acc),
        .we       (b_we),
        .off      (byte_addr[OFF_W-1:0]),
        .wdata    (b_wdata),
        .rdata    (cfg_rdata),
        .win_en   (win_en),
        .win_base (win_base)
    );

    always_comb begin
        sys_req = b_active && (tgt == TGT_SYS);
        nfc_req = b_active && (tgt == TGT_NFC);
        cfg_acc = b_active && (tgt == TGT_CFG);
        case (tgt)
            TGT_SYS: b_rdata = sys_rdata;
            TGT_CFG: b_rdata = cfg_rdata;
            TGT_NFC: b_rdata = nfc_rdata;
            default: b_rdata = 8'h00;
        endcase
    end

    assign sys_we    = b_we;
    assign sys_off   = byte_addr[OFF_W-1:0];
    assign sys_wdata = b_wdata;
    assign nfc_we    = b_we;
    assign nfc_off   = byte_addr[OFF_W-1:0];
    assign nfc_wdata = b_wdata;

endmodule

// File: rtl/ccd_checker.sv
module ccd_checker #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int BASE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic              host_done,
    input logic              sys_req,
    input logic              nfc_req,
    input logic [OFF_W-1:0]  sys_off,
    input logic [OFF_W-1:0]  nfc_off,
    input logic [ADDR_W-1:0] byte_addr,
    input logic              win_en,
    input logic [BASE_W-1:0] win_base
);

    // R4: at most one external target per byte
    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_req, nfc_req}));

    // R1: system requests only for page 0, offset from the low byte
    p_sys_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req |-> (byte_addr[ADDR_W-1:OFF_W] == '0) && (sys_off == byte_addr[OFF_W-1:0]));

    // R4: NAND requests only inside the enabled window
    p_nfc_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nfc_req |-> win_en
                    && (win_base == BASE_W'({byte_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}))
                    && (nfc_off == byte_addr[OFF_W-1:0]));

    // R7: accepting an access makes the host port busy
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> !host_ready);

    // R7: completion lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    // R7: completion only follows a busy cycle
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> $past(!host_ready));

    // R8: state right after reset release
    p_reset_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!win_en && (win_base == '0) && host_ready && !sys_req && !nfc_req));

endmodule

bind ccd_router ccd_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .BASE_W (BASE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_done  (host_done),
    .sys_req    (sys_req),
    .nfc_req    (nfc_req),
    .sys_off    (sys_off),
    .nfc_off    (nfc_off),
    .byte_addr  (byte_addr),
    .win_en     (win_en),
    .win_base   (win_base)
);

// File: tb/ccd_router_bench.sv
module ccd_router_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [15:0] host_addr = 16'h0;
    logic [31:0] host_wdata = 32'h0;
    logic        host_ready, host_done;
    logic [31:0] host_rdata;
    logic        sys_req, sys_we, nfc_req, nfc_we;
    logic [7:0]  sys_off, sys_wdata, sys_rdata, nfc_off, nfc_wdata, nfc_rdata;

    logic [7:0]  sys_mem [256];
    logic [7:0]  nfc_mem [256];
    logic [7:0]  exp_sys [256];
    logic [7:0]  exp_nfc [256];
    logic        m_en;
    logic [31:0] m_base;
    logic [8:0]  log_ent [16];
    int          log_total = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_router u_ccd_router (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write), .host_size(host_size),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .sys_req(sys_req), .sys_we(sys_we), .sys_off(sys_off),
        .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
        .nfc_req(nfc_req), .nfc_we(nfc_we), .nfc_off(nfc_off),
        .nfc_wdata(nfc_wdata), .nfc_rdata(nfc_rdata)
    );

    // Target models: combinational read, write at the clock edge
    assign sys_rdata = sys_mem[sys_off];
    assign nfc_rdata = nfc_mem[nfc_off];

    always @(posedge clk) begin
        if (sys_req && sys_we) sys_mem[sys_off] <= sys_wdata;
        if (nfc_req && nfc_we) nfc_mem[nfc_off] <= nfc_wdata;
        if (sys_req || nfc_req) begin
            log_ent[log_total % 16] <= {nfc_req, sys_req ? sys_off : nfc_off};
            log_total <= log_total + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: expired, actual %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_errors = n_errors + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    // Reference model of one access, applied byte by byte in ascending order
    task automatic model(input bit we, input logic [1:0] sz, input logic [15:0] a,
                         input logic [31:0] wd, output logic [31:0] r, output int n);
        n = (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
        r = 32'h0;
        for (int k = 0; k < n; k++) begin
            logic [15:0] ba;
            logic [7:0]  wb, rb;
            int          l;
            ba = a + 16'(k);
            wb = wd[8*k +: 8];
            rb = 8'h00;
            if (ba[15:8] == 8'h00) begin
                if (we) exp_sys[ba[7:0]] = wb; else rb = exp_sys[ba[7:0]];
            end else if (ba[15:8] == 8'h01) begin
                if (ba[7:0] == 8'h04) begin
                    if (we) m_en = wb[1]; else rb = {6'd0, m_en, 1'b0};
                end else if (ba[7:0] >= 8'h10 && ba[7:0] <= 8'h13) begin
                    l = int'(ba[7:0]) - 16;
                    if (we) m_base[8*l +: 8] = wb; else rb = m_base[8*l +: 8];
                end
            end else if (m_en && (m_base == {16'h0, ba[15:8], 8'h00})) begin
                if (we) exp_nfc[ba[7:0]] = wb; else rb = exp_nfc[ba[7:0]];
            end
            if (!we) r[8*k +: 8] = rb;
        end
    endtask

    task automatic do_acc(input bit we, input logic [1:0] sz, input logic [15:0] a,
                          input logic [31:0] wd, input string tag);
        logic [31:0] expr;
        int          n, cnt, bad;
        model(we, sz, a, wd, expr, n);
        @(negedge clk);
        host_valid = 1'b1; host_write = we; host_size = sz;
        host_addr = a; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        chk(host_ready == 1'b0, "R7", "ready low while busy", host_ready, 0);
        cnt = 1;
        while (!host_done && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == n + 1, "R7", "cycles to done", cnt, n + 1);
        if (!we) begin
            chk(host_rdata == expr, tag, "read data", host_rdata, expr);
        end else begin
            chk(host_rdata == 32'h0, "R7", "write rdata zero", host_rdata, 0);
            bad = 0;
            for (int i = 0; i < 256; i++) begin
                if (sys_mem[i] !== exp_sys[i] || nfc_mem[i] !== exp_nfc[i]) bad++;
            end
            chk(bad == 0, tag, "target contents after write", bad, 0);
        end
    endtask

    initial begin
        int          start;
        logic [7:0]  win_pg;
        logic [15:0] a;
        for (int i = 0; i < 256; i++) begin
            sys_mem[i] = 8'(i * 7 + 3);
            exp_sys[i] = 8'(i * 7 + 3);
            nfc_mem[i] = 8'(i) ^ 8'hA5;
            exp_nfc[i] = 8'(i) ^ 8'hA5;
        end
        m_en = 1'b0;
        m_base = 32'h0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk(host_ready == 1'b1, "R8", "ready after reset", host_ready, 1);
        chk(!sys_req && !nfc_req, "R8", "no target request", {sys_req, nfc_req}, 0);
        do_acc(0, 2'd0, 16'h0104, 0, "R8");
        do_acc(0, 2'd2, 16'h0110, 0, "R8");

        // R1 system page
        do_acc(1, 2'd0, 16'h0023, 32'h5A, "R1");
        do_acc(0, 2'd0, 16'h0023, 0, "R1");
        do_acc(0, 2'd2, 16'h0040, 0, "R1");

        // R5 ascending order of a word write
        start = log_total;
        do_acc(1, 2'd2, 16'h0010, 32'hDDCCBBAA, "R5");
        chk(log_total - start == 4, "R5", "byte count", log_total - start, 4);
        for (int k = 0; k < 4; k++)
            chk(log_ent[(start + k) % 16] == {1'b0, 8'(8'h10 + k)}, "R5", "byte order",
                log_ent[(start + k) % 16], {1'b0, 8'(8'h10 + k)});
        do_acc(0, 2'd1, 16'h0012, 0, "R5");

        // R3 base bytes
        do_acc(1, 2'd0, 16'h0112, 32'h56, "R3");
        do_acc(0, 2'd2, 16'h0110, 0, "R3");
        do_acc(1, 2'd1, 16'h0110, 32'h3400, "R3");
        do_acc(0, 2'd0, 16'h0111, 0, "R3");

        // R2 command register
        do_acc(1, 2'd0, 16'h0104, 32'h02, "R2");
        do_acc(0, 2'd0, 16'h0104, 0, "R2");
        // R4 upper base bits nonzero: no match
        do_acc(0, 2'd0, 16'h3405, 0, "R4");
        do_acc(1, 2'd0, 16'h0112, 32'h00, "R3");
        do_acc(0, 2'd0, 16'h3405, 0, "R4");
        do_acc(1, 2'd1, 16'h3406, 32'h9988, "R4");
        do_acc(0, 2'd2, 16'h3404, 0, "R4");
        // R4 nonzero low base byte: no match
        do_acc(1, 2'd0, 16'h0110, 32'h01, "R4");
        do_acc(0, 2'd0, 16'h3406, 0, "R4");
        do_acc(1, 2'd0, 16'h0110, 32'h00, "R4");
        // R4 base on page 1: configuration page wins
        do_acc(1, 2'd2, 16'h0110, 32'h00000100, "R4");
        do_acc(0, 2'd0, 16'h0104, 0, "R4");
        do_acc(1, 2'd2, 16'h0110, 32'h00003400, "R4");

        // R2 disable via bit 1 clear, write dropped, re-enable
        do_acc(1, 2'd0, 16'h0104, 32'hFD, "R2");
        do_acc(0, 2'd0, 16'h0104, 0, "R2");
        do_acc(1, 2'd0, 16'h3410, 32'h77, "R6");
        do_acc(1, 2'd0, 16'h0104, 32'h02, "R2");
        do_acc(0, 2'd0, 16'h3410, 0, "R6");

        // R6 unmatched
        do_acc(1, 2'd0, 16'h0105, 32'hEE, "R6");
        do_acc(0, 2'd0, 16'h0105, 0, "R6");
        do_acc(1, 2'd2, 16'h5500, 32'h12345678, "R6");
        do_acc(0, 2'd2, 16'h5500, 0, "R6");

        // R5 page crossing, wrap and reserved size
        do_acc(0, 2'd2, 16'h00FE, 0, "R5");
        do_acc(0, 2'd2, 16'hFFFE, 0, "R5");
        do_acc(0, 2'd3, 16'h0041, 32'hFFFFFFFF, "R5");
        do_acc(1, 2'd2, 16'h34FE, 32'hCAFEF00D, "R5");

        // Random mix (R1, R3, R4, R5, R6)
        win_pg = 8'h34;
        for (int t = 0; t < 400; t++) begin
            int       sel;
            bit       we;
            logic [1:0] sz;
            sel = int'($urandom % 10);
            we  = $urandom % 2 == 1;
            sz  = 2'($urandom % 4);
            case (sel)
                0, 1, 2: a = {8'h00, 8'($urandom)};
                3: begin
                    case ($urandom % 3)
                        0: a = 16'h0104;
                        1: a = 16'h0110 + 16'($urandom % 4);
                        default: a = {8'h01, 8'($urandom)};
                    endcase
                end
                4, 5, 6: a = {win_pg, 8'($urandom)};
                7, 8: a = 16'($urandom);
                default: begin
                    win_pg = 8'(2 + $urandom % 254);
                    do_acc(1, 2'd2, 16'h0110, {16'h0, win_pg, 8'h00}, "R4");
                    do_acc(1, 2'd0, 16'h0104, ($urandom % 4 != 0) ? 32'h2 : 32'h0, "R2");
                    a = {win_pg, 8'($urandom)};
                end
            endcase
            do_acc(we, sz, a, $urandom, "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule